// File: doc/BRIEF.md
# Quadrature Input Decoder Front-End

This block sits between the synchronised encoder pins and a position counter. It takes the two phase lines and the index line of an incremental encoder. It produces a single-cycle count strobe with a direction bit, an index-load strobe, and a sticky flag that reports a corrupted phase sequence. The counter arithmetic and any register access live elsewhere. The downstream counter adds or subtracts one on every strobe. It loads its preset value on every index-load strobe.

There are two clocking modes. In plain mode, both the phase filter and the decoder are skipped. Each rising edge of phase A is one count, and the level of phase B picks the direction. In quadrature mode, each phase first passes through a stability filter. The decoder then turns the filtered (A, B) state changes into up or down steps. Three resolutions are available: one, two or four counts per encoder cycle. The index line can act straight from its level (active low), or it can act in step with the decoded count clock at a selectable polarity.

Top module: `quad_decoder_fe`

## Requirements
- R1: While rst_ni is low, and on the first clock after it rises, cnt_o, dir_o, idx_load_o and noise_err_o are all 0.
- R2: With quad_en_i=0, each rising edge of a_i seen at a clock edge raises cnt_o for one cycle, starting at that edge. At the same edge, dir_o takes the value of b_i (1 = up, 0 = down). A pulse on a_i that lasts one clock is enough. scale_i has no effect in this mode.
- R3: With quad_en_i=1, a new phase level is accepted only after it has been sampled on 3 consecutive clock edges. The count strobe for that change appears at the 4th edge. A level held for 2 edges and then withdrawn produces no count.
- R4: With quad_en_i=1 and scale_i=2 (x4), every legal step of the filtered state counts once. The (A,B) order 00, 10, 11, 01 gives dir_o=1 (up). The reverse order gives dir_o=0.
- R5: With scale_i=1 (x2), only steps in which phase A changes are counted, which gives two counts per encoder cycle.
- R6: With scale_i=0 or 3 (x1), only a step between (A,B)=00 and (A,B)=10 counts: up when going from 00 to 10, down when going from 10 to 00. This gives one count per encoder cycle.
- R7: With ab_en_i=0, cnt_o stays 0 in every mode.
- R8: In quadrature mode, a filtered update in which A and B change together sets noise_err_o and produces no count.
- R9: noise_err_o stays set until a cycle with err_clr_i=1. If a new illegal step lands in the same cycle, the set wins. With quad_en_i=0 the flag is never set.
- R10: In direct index mode, idx_load_o equals the inverse of idx_i, one clock later, whatever the value of idx_pol_i.
- R11: In synchronous index mode (sync_idx_en_i=1 and quad_en_i=1), idx_load_o is high only in the same cycle as a count strobe, and only when idx_i equaled idx_pol_i at that step.
- R12: With quad_en_i=0, sync_idx_en_i is ignored and the index acts as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Phase A, already synchronised |
| b_i | input | 1 | Phase B, already synchronised |
| idx_i | input | 1 | Index input, already synchronised |
| quad_en_i | input | 1 | 1 = quadrature decoding, 0 = plain clock/direction |
| scale_i | input | 2 | 0,3 = x1; 1 = x2; 2 = x4 |
| ab_en_i | input | 1 | Enables counting |
| sync_idx_en_i | input | 1 | Index acts in step with the decoded clock |
| idx_pol_i | input | 1 | Active index level in synchronous mode |
| err_clr_i | input | 1 | Clears the noise flag |
| cnt_o | output | 1 | One-cycle count strobe |
| dir_o | output | 1 | Direction of the last strobe, 1 = up |
| idx_load_o | output | 1 | Index-load strobe or level |
| noise_err_o | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest condition to reach is an illegal transition that gets past the filter. Both phases must reach their 3-sample acceptance on the same edge, so the stimulus flips A and B in the same cycle from a settled state and holds them. The other hard condition is a near-miss of the filter. It is produced by holding a flipped phase for exactly two sample edges and then restoring it, followed by a check of the exact edge at which a properly held change produces its strobe. For synchronous index, idx_i is held at the active and the inactive level while the encoder steps, and the bench compares index strobes against count strobes.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    SCL_X1  = 2'd0,
    SCL_X2  = 2'd1,
    SCL_X4  = 2'd2,
    SCL_RSV = 2'd3
  } scale_e;

  // position along the up sequence 00,10,11,01 of (A,B)
  function automatic logic [1:0] phase_pos(input logic a, input logic b);
    return {b, a ^ b};
  endfunction
endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] ACCEPT = CW'(FILT_LEN - 1);

  logic          last_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      run_q  <= '0;
      filt_o <= 1'b0;
    end else if (raw_i != last_q) begin
      last_q <= raw_i;
      run_q  <= CW'(1);
    end else if (run_q < ACCEPT) begin
      run_q <= run_q + CW'(1);
    end else begin
      filt_o <= last_q;
    end
  end
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       quad_en_i,
  input  logic [1:0] scale_i,
  input  logic       a_raw_i,
  input  logic       b_raw_i,
  input  logic       a_filt_i,
  input  logic       b_filt_i,
  output logic       step_o,
  output logic       up_o,
  output logic       illegal_o
);
  logic pa_q, pb_q, a_raw_q;
  logic [1:0] old_pos, new_pos;
  logic fwd, bwd, a_chg, both_chg;
  logic q_step;
  scale_e scl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q    <= 1'b0;
      pb_q    <= 1'b0;
      a_raw_q <= 1'b0;
    end else begin
      pa_q    <= a_filt_i;
      pb_q    <= b_filt_i;
      a_raw_q <= a_raw_i;
    end
  end

  always_comb begin
    scl      = scale_e'(scale_i);
    old_pos  = phase_pos(pa_q, pb_q);
    new_pos  = phase_pos(a_filt_i, b_filt_i);
    fwd      = (new_pos == old_pos + 2'd1);
    bwd      = (new_pos == old_pos - 2'd1);
    a_chg    = a_filt_i ^ pa_q;
    both_chg = a_chg & (b_filt_i ^ pb_q);
    unique case (scl)
      SCL_X4:  q_step = fwd | bwd;
      SCL_X2:  q_step = a_chg & ~both_chg;
      default: q_step = (fwd & (old_pos == 2'd0)) | (bwd & (old_pos == 2'd1));
    endcase
    if (quad_en_i) begin
      step_o    = q_step;
      up_o      = fwd;
      illegal_o = both_chg;
    end else begin
      step_o    = a_raw_i & ~a_raw_q;
      up_o      = b_raw_i;
      illegal_o = 1'b0;
    end
  end
endmodule

// File: rtl/qdec_index.sv
module qdec_index (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idx_i,
  input  logic pol_i,
  input  logic sync_i,
  input  logic strobe_i,
  output logic load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     load_o <= 1'b0;
    else if (sync_i) load_o <= strobe_i & (idx_i == pol_i);
    else             load_o <= ~idx_i;
  end
endmodule

// File: rtl/quad_decoder_fe.sv
module quad_decoder_fe #(
  parameter int FILT_LEN = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       idx_i,
  input  logic       quad_en_i,
  input  logic [1:0] scale_i,
  input  logic       ab_en_i,
  input  logic       sync_idx_en_i,
  input  logic       idx_pol_i,
  input  logic       err_clr_i,
  output logic       cnt_o,
  output logic       dir_o,
  output logic       idx_load_o,
  output logic       noise_err_o
);
  localparam int NPH = 2;

  logic [NPH-1:0] raw, filt;
  logic step, up, illegal, cnt_d;

  assign raw = {b_i, a_i};

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    qdec_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .filt_o (filt[g])
    );
  end

  qdec_step u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .quad_en_i (quad_en_i),
    .scale_i   (scale_i),
    .a_raw_i   (a_i),
    .b_raw_i   (b_i),
    .a_filt_i  (filt[0]),
    .b_filt_i  (filt[1]),
    .step_o    (step),
    .up_o      (up),
    .illegal_o (illegal)
  );

  assign cnt_d = step & ab_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= 1'b0;
      dir_o       <= 1'b0;
      noise_err_o <= 1'b0;
    end else begin
      cnt_o <= cnt_d;
      if (cnt_d) dir_o <= up;
      if (illegal)        noise_err_o <= 1'b1;
      else if (err_clr_i) noise_err_o <= 1'b0;
    end
  end

  qdec_index u_idx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_i    (idx_i),
    .pol_i    (idx_pol_i),
    .sync_i   (sync_idx_en_i & quad_en_i),
    .strobe_i (cnt_d),
    .load_o   (idx_load_o)
  );
endmodule

module qdec_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic b_i,
  input logic quad_en_i,
  input logic ab_en_i,
  input logic sync_idx_en_i,
  input logic err_clr_i,
  input logic cnt_o,
  input logic dir_o,
  input logic idx_load_o,
  input logic noise_err_o
);
  // R7
  ab_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ab_en_i) |-> !cnt_o);
  // R2
  plain_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o && !$past(quad_en_i)) |-> (dir_o == $past(b_i)));
  // R8
  illegal_nocount_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(noise_err_o) |-> !cnt_o);
  // R9
  noise_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(noise_err_o) |-> $past(err_clr_i));
  // R9
  noise_quad_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(noise_err_o) |-> $past(quad_en_i));
  // R11
  sync_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sync_idx_en_i && quad_en_i) && idx_load_o) |-> cnt_o);
endmodule

bind quad_decoder_fe qdec_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .b_i           (b_i),
  .quad_en_i     (quad_en_i),
  .ab_en_i       (ab_en_i),
  .sync_idx_en_i (sync_idx_en_i),
  .err_clr_i     (err_clr_i),
  .cnt_o         (cnt_o),
  .dir_o         (dir_o),
  .idx_load_o    (idx_load_o),
  .noise_err_o   (noise_err_o)
);

// File: tb/quad_decoder_fe_tb_top.sv
`timescale 1ns/1ps
module quad_decoder_fe_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 0, b = 0, idx = 1, quad_en = 0, ab_en = 0, sync_en = 0, pol = 0, clr = 0;
  logic [1:0] scale = 2'd0;
  logic cnt, dir, idx_ld, nerr;
  int checks = 0, fails = 0;
  int up_n = 0, dn_n = 0, ix_n = 0;

  always #5 clk = ~clk;

  quad_decoder_fe dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .idx_i(idx),
    .quad_en_i(quad_en), .scale_i(scale), .ab_en_i(ab_en),
    .sync_idx_en_i(sync_en), .idx_pol_i(pol), .err_clr_i(clr),
    .cnt_o(cnt), .dir_o(dir), .idx_load_o(idx_ld), .noise_err_o(nerr)
  );

  always @(negedge clk) if (rst_n) begin
    if (cnt) begin
      if (dir) up_n++;
      else dn_n++;
    end
    if (idx_ld) ix_n++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_tally();
    tick(8);
    up_n = 0; dn_n = 0; ix_n = 0;
  endtask

  task automatic qstep(input bit fwd);
    logic [1:0] p;
    p = {b, a ^ b};
    p = fwd ? p + 2'd1 : p - 2'd1;
    a = p[0] ^ p[1];
    b = p[1];
    tick(5);
  endtask

  task automatic pulse_a(input bit bl);
    b = bl;
    a = 1'b1;
    tick(1);
    a = 1'b0;
    tick(4);
  endtask

  task automatic t_reset();
    tick(1);
    chk_eq("R1 cnt in reset", cnt, 0);
    chk_eq("R1 idx in reset", idx_ld, 0);
    rst_n = 1'b1;
    tick(1);
    chk_eq("R1 cnt after reset", cnt, 0);
    chk_eq("R1 dir after reset", dir, 0);
    chk_eq("R1 noise after reset", nerr, 0);
  endtask

  task automatic t_plain();
    quad_en = 0; ab_en = 1; scale = 2'd2;
    clr_tally();
    b = 1; a = 1;
    tick(1);
    chk_eq("R2 strobe one edge after A rise", cnt, 1);
    chk_eq("R2 dir follows B=1", dir, 1);
    a = 0;
    tick(1);
    chk_eq("R2 strobe lasts one cycle", cnt, 0);
    tick(3);
    for (int i = 0; i < 3; i++) pulse_a(1'b0);
    tick(4);
    chk_eq("R2 up count x1 despite scale", up_n, 1);
    chk_eq("R2 down count", dn_n, 3);
  endtask

  task automatic t_x4();
    quad_en = 1; scale = 2'd2; b = 0; a = 0;
    clr_tally();
    for (int i = 0; i < 8; i++) qstep(1'b1);
    tick(4);
    chk_eq("R4 x4 up", up_n, 8);
    chk_eq("R4 x4 no down", dn_n, 0);
    for (int i = 0; i < 4; i++) qstep(1'b0);
    tick(4);
    chk_eq("R4 x4 down", dn_n, 4);
  endtask

  task automatic t_x2_x1();
    scale = 2'd1;
    clr_tally();
    for (int i = 0; i < 8; i++) qstep(1'b1);
    tick(4);
    chk_eq("R5 x2 up", up_n, 4);
    scale = 2'd0;
    clr_tally();
    for (int i = 0; i < 8; i++) qstep(1'b1);
    tick(4);
    chk_eq("R6 x1 up", up_n, 2);
    scale = 2'd3;
    clr_tally();
    for (int i = 0; i < 4; i++) qstep(1'b0);
    tick(4);
    chk_eq("R6 scale3 down", dn_n, 1);
    chk_eq("R6 scale3 no up", up_n, 0);
  endtask

  task automatic t_filter();
    scale = 2'd2;
    clr_tally();
    a = ~a;
    tick(2);
    a = ~a;
    tick(8);
    chk_eq("R3 two-sample glitch ignored", up_n + dn_n, 0);
    a = ~a;
    tick(3);
    chk_eq("R3 no strobe before 4th edge", cnt, 0);
    tick(1);
    chk_eq("R3 strobe at 4th edge", cnt, 1);
    tick(4);
  endtask

  task automatic t_abdis();
    ab_en = 0;
    clr_tally();
    for (int i = 0; i < 8; i++) qstep(1'b1);
    quad_en = 0;
    for (int i = 0; i < 3; i++) pulse_a(1'b1);
    tick(4);
    chk_eq("R7 no strobes when disabled", up_n + dn_n, 0);
    ab_en = 1; quad_en = 1;
    tick(8);
  endtask

  task automatic t_noise();
    quad_en = 1; scale = 2'd2;
    clr_tally();
    chk_eq("R8 flag clear before", nerr, 0);
    a = ~a; b = ~b;
    tick(8);
    chk_eq("R8 flag set on double change", nerr, 1);
    chk_eq("R8 no count on double change", up_n + dn_n, 0);
    qstep(1'b1);
    tick(2);
    chk_eq("R9 flag sticky", nerr, 1);
    clr = 1;
    tick(1);
    clr = 0;
    chk_eq("R9 flag cleared", nerr, 0);
    quad_en = 0;
    tick(4);
    a = ~a; b = ~b;
    tick(8);
    chk_eq("R9 no flag in plain mode", nerr, 0);
    quad_en = 1;
    tick(8);
  endtask

  task automatic t_index();
    quad_en = 0; sync_en = 0; pol = 1;
    idx = 0;
    tick(1);
    chk_eq("R10 low index active", idx_ld, 1);
    idx = 1;
    tick(1);
    chk_eq("R10 high index inactive", idx_ld, 0);
    sync_en = 1; idx = 0;
    tick(1);
    chk_eq("R12 sync ignored in plain mode", idx_ld, 1);
    quad_en = 1; scale = 2'd2; pol = 1; idx = 1;
    clr_tally();
    chk_eq("R11 no index without step", ix_n, 0);
    for (int i = 0; i < 4; i++) qstep(1'b1);
    tick(4);
    chk_eq("R11 index per strobe active high", ix_n, up_n);
    chk_eq("R11 index count", ix_n, 4);
    idx = 0;
    clr_tally();
    for (int i = 0; i < 4; i++) qstep(1'b1);
    tick(4);
    chk_eq("R11 inactive level no load", ix_n, 0);
    pol = 0;
    clr_tally();
    for (int i = 0; i < 2; i++) qstep(1'b0);
    tick(4);
    chk_eq("R11 active low polarity", ix_n, 2);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_plain();
    t_x4();
    t_x2_x1();
    t_filter();
    t_abdis();
    t_noise();
    t_index();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule